// File: doc/BRIEF.md
# Display Mode Selector

This block picks which of four display items a wristwatch face shows. A single push-button input steps the face through current time, alarm setting, stopwatch and calendar date, then returns to current time. The block keeps the selected item in a 2-bit register and also routes the matching data word to the display through a 4-way multiplexer. The width of that word is a parameter.

A press is recognised on the first clock cycle where the button reads 1 after reading 0. The selection steps forward once for each press, however long the button stays down. The button input must already be synchronous to the clock and free of bounce. The select register changes only on a rising clock edge. The data output follows the select register and the four data inputs combinationally.

Top module: `disp_mode_sel`

## Requirements
- R1: The reset is synchronous and active low. While `rst_n` is 0 at a rising edge, that edge sets `sel` to 00 (time) and clears the stored previous button level. If the button is still held when reset is released, the first edge after release therefore counts as a new press.
- R2: `sel` encodes the shown item. 00 is time, 01 is alarm, 10 is stopwatch and 11 is date. `disp_data` equals `time_data`, `alarm_data`, `stopw_data` or `date_data` for these codes respectively.
- R3: On a rising edge where `btn` is 1 and `btn` was 0 at the previous edge (or reset was applied at the previous edge), `sel` steps to the next code.
- R4: The stepping order is 00, 01, 10, 11, and 11 wraps back to 00.
- R5: While `btn` stays at 1 over consecutive edges, only the first of those edges changes `sel`.
- R6: On any edge without a press, including edges where `btn` is 0, `sel` keeps its value.
- R7: `disp_data` is combinational from the registered `sel` and the data inputs. A change on the selected data input shows on `disp_data` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| btn | input | 1 | Advance button, synchronous and debounced |
| time_data | input | DATA_W | Word shown for code 00 |
| alarm_data | input | DATA_W | Word shown for code 01 |
| stopw_data | input | DATA_W | Word shown for code 10 |
| date_data | input | DATA_W | Word shown for code 11 |
| sel | output | 2 | Registered item select |
| disp_data | output | DATA_W | Selected data word for the display |

## Verification
The bench builds the block with `DATA_W` set to 12 rather than the default of 8. The extra width gives room for four clearly different random words on the data inputs, so a routing error on any bit shows up. Random button streams with long holds and short taps drive the selector through many wraps. Directed cases cover a hold across several cycles, a reset issued while the button is down, and data changes in the middle of a cycle.

// File: rtl/disp_mode_pkg.sv
// Package for the display mode selector. It holds the item encoding and
// the stepping function. The select codes are fixed, because an external
// decoder reads them directly.
package disp_mode_pkg;

    localparam int MODE_CNT = 4;
    localparam int SEL_W    = $clog2(MODE_CNT);

    typedef enum logic [SEL_W-1:0] {
        MODE_TIME  = 2'b00,
        MODE_ALARM = 2'b01,
        MODE_STOPW = 2'b10,
        MODE_DATE  = 2'b11
    } mode_t;

    // Next item in the display order; the last code wraps to the first
    function automatic mode_t mode_step(input mode_t cur);
        logic [SEL_W-1:0] v;
        v = cur;
        v = v + {{(SEL_W-1){1'b0}}, 1'b1};
        return mode_t'(v);
    endfunction

endpackage

// File: rtl/btn_press_det.sv
// Press detector. It keeps the button level sampled at the last edge and
// flags a press when the button reads 1 now and read 0 then. Assumes the
// button is already synchronous and debounced. Reset clears the history.
module btn_press_det (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_i,
    output logic press_o
);

    logic btn_q;

    // Store the button level seen at each edge
    always_ff @(posedge clk) begin
        if (!rst_n) btn_q <= 1'b0;
        else        btn_q <= btn_i;
    end

    // A press is a 0 to 1 step between two sampled levels
    always_comb press_o = btn_i & ~btn_q;

    // R5: a press flag never stands on two edges in a row
    p_single_press_r5: assert property (@(posedge clk) disable iff (!rst_n)
        press_o |=> !press_o);

endmodule

// File: rtl/disp_mode_seq.sv
// Mode sequencer. It holds the current item and steps it once for each
// press pulse. Assumes a press pulse lasts one cycle. Reset selects time.
module disp_mode_seq
    import disp_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  press_i,
    output mode_t mode_o
);

    // Move to the next item on a press and hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_o <= MODE_TIME;
        else if (press_i) mode_o <= mode_step(mode_o);
    end

    // R3: a press moves the select forward by exactly one code
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        press_i |=> (mode_o == mode_t'($past(mode_o) + 2'd1)));

    // R4: the date code is followed by the time code
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (press_i && mode_o == MODE_DATE) |=> (mode_o == MODE_TIME));

    // R6: without a press the select does not move
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !press_i |=> $stable(mode_o));

endmodule

// File: rtl/disp_data_mux.sv
// Display data multiplexer. It passes one of MODE_CNT source words,
// indexed by the select code. It is purely combinational. Assumes the
// sources are packed with source 0 in the lowest bits.
module disp_data_mux
    import disp_mode_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [MODE_CNT*DATA_W-1:0] src_i,
    input  mode_t                      sel_i,
    output logic [DATA_W-1:0]          out_o
);

    logic [DATA_W-1:0] src_arr [MODE_CNT];

    // Unpack the source bus into one word per item
    for (genvar g = 0; g < MODE_CNT; g++) begin : g_unpack
        assign src_arr[g] = src_i[g*DATA_W +: DATA_W];
    end

    // Route the selected word through
    always_comb out_o = src_arr[sel_i];

endmodule

// File: rtl/disp_mode_sel.sv
// Display mode selector top. It joins the press detector, the sequencer
// and the data multiplexer. Assumes btn is synchronous and debounced.
// sel changes only on a rising clock edge.
module disp_mode_sel
    import disp_mode_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              btn,
    input  logic [DATA_W-1:0] time_data,
    input  logic [DATA_W-1:0] alarm_data,
    input  logic [DATA_W-1:0] stopw_data,
    input  logic [DATA_W-1:0] date_data,
    output logic [1:0]        sel,
    output logic [DATA_W-1:0] disp_data
);

    logic  press;
    mode_t mode;

    btn_press_det u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_i   (btn),
        .press_o (press)
    );

    disp_mode_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .press_i (press),
        .mode_o  (mode)
    );

    disp_data_mux #(.DATA_W(DATA_W)) u_mux (
        .src_i ({date_data, stopw_data, alarm_data, time_data}),
        .sel_i (mode),
        .out_o (disp_data)
    );

    // Drive the select port from the sequencer state
    always_comb sel = mode;

    // R1: the first edge after reset release sees the time code
    p_reset_time_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sel == 2'b00));

    // R2: the date code routes the date word, the time code the time word
    p_date_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b11) |-> (disp_data == date_data));
    p_time_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00) |-> (disp_data == time_data));

endmodule

// File: tb/disp_mode_sel_tb_top.sv
module disp_mode_sel_tb_top;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         btn = 1'b0;
    logic [W-1:0] td = '0, ad = '0, sd = '0, dd = '0;
    logic [1:0]   sel;
    logic [W-1:0] disp;

    int n_run = 0;
    int n_fail = 0;
    logic [1:0] exp_sel = 2'b00;
    logic       prev_btn = 1'b0;

    always #10 clk = ~clk;

    disp_mode_sel #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .btn(btn),
        .time_data(td), .alarm_data(ad), .stopw_data(sd), .date_data(dd),
        .sel(sel), .disp_data(disp)
    );

    function automatic logic [W-1:0] exp_disp(input logic [1:0] s);
        case (s)
            2'b00:   return td;
            2'b01:   return ad;
            2'b10:   return sd;
            default: return dd;
        endcase
    endfunction

    task automatic chk_sel(input string req);
        n_run++;
        if (sel !== exp_sel) begin
            n_fail++;
            $display("FAIL %s sel actual=%b expected=%b", req, sel, exp_sel);
        end
    endtask

    task automatic chk_disp(input string req);
        n_run++;
        if (disp !== exp_disp(exp_sel)) begin
            n_fail++;
            $display("FAIL %s disp actual=%h expected=%h", req, disp, exp_disp(exp_sel));
        end
    endtask

    task automatic rand_data();
        td = W'($urandom); ad = W'($urandom);
        sd = W'($urandom); dd = W'($urandom);
    endtask

    // One clock: check the state left by the last edge, then drive new inputs
    task automatic step(input logic b, input string req);
        @(negedge clk);
        chk_sel(req);
        chk_disp("R2");
        btn = b;
        rand_data();
        #1 chk_disp("R7");
        if (b && !prev_btn) exp_sel = exp_sel + 2'd1;
        prev_btn = b;
    endtask

    // One clock with reset asserted
    task automatic rst_step(input logic b);
        @(negedge clk);
        rst_n = 1'b0;
        btn = b;
        exp_sel = 2'b00;
        prev_btn = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk_sel("R1");
        if (b) exp_sel = 2'b01;
        prev_btn = b;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        rand_data();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset value
        chk_sel("R1");
        // R3 and R4: four separate taps walk the whole order and wrap
        for (int i = 0; i < 4; i++) begin
            step(1'b1, "R3");
            step(1'b0, "R4");
        end
        step(1'b0, "R4");
        // R5: long hold advances once
        for (int i = 0; i < 10; i++) step(1'b1, "R5");
        step(1'b0, "R5");
        // R6: idle keeps the item
        for (int i = 0; i < 6; i++) step(1'b0, "R6");
        // R7: mid-cycle change of every source shows at once
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rand_data();
            #3 chk_disp("R7");
        end
        // R1: reset while held, then the held level counts as a press
        step(1'b1, "R3");
        rst_step(1'b1);
        for (int i = 0; i < 3; i++) step(1'b1, "R1");
        step(1'b0, "R1");
        // Random streams of taps and holds
        for (int i = 0; i < 3000; i++) begin
            logic b;
            b = ($urandom_range(0, 9) < 4);
            step(b, "R3");
            if ($urandom_range(0, 199) == 0) rst_step(btn);
        end
        step(1'b0, "R6");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule